// File: doc/BRIEF.md
# Vector Sub-Word Shuffle Unit

This block assembles a new vector from pieces of two source vectors. The vector is LANES x 32 bits wide. A two-bit code sets the sub-word size to 8, 16, 32 or 64 bits. The block then cuts the vector into that many equal sub-words. For each destination slot, the block uses a four-entry control pattern to pick the source and the position to copy from. Each entry holds a two-bit position index and a one-bit source select. A 4-bit select field and an 8-bit index field carry the four entries.

Slots 0 to 3 use the pattern as written. Each later group of four slots reuses the same four entries, with the source position moved up by the group number. In this way a single short pattern can move structured data across the whole vector.

The unit captures its result into a register when the start strobe is high. It raises the valid flag for exactly one cycle, one clock edge after the strobe. Instruction decode and the register file lie outside the block.

Top module: `vshuf_unit`

## Requirements
- R1: While reset is active, and after it is released, `result` is all zeros and `valid` is 0 until the first start.
- R2: `valid` is 1 in the cycle after a cycle with `start` high, and 0 in the cycle after a cycle with `start` low.
- R3: When `start` is low, `result` keeps its value, whatever the other inputs do.
- R4: The sub-word width depends on `width_code`: 00 gives 8 bits, 01 gives 16 bits, 10 gives 32 bits and 11 gives 64 bits. Sub-word k occupies bits [k*W+W-1 : k*W].
- R5: Entry g (0..3) takes its position index from `idx_field[7-2g:6-2g]` and its source select from `sel_field[3-g]`. Entry 0 therefore sits in the most significant bits of each field.
- R6: For destination slot i in 0..3, the value is sub-word n[i] of `src_a` when s[i]=0, and sub-word n[i] of `src_b` when s[i]=1.
- R7: For destination slot i of 4 or more, the value is sub-word n[i mod 4] + i/4 of the source chosen by s[i mod 4].
- R8: If `width_code` selects a sub-word wider than LANES*32/4 bits, the captured result is all zeros.
- R9: Take 16-bit sub-words, index field 10110110 and select field 0011. The result bits 31:0 then equal `src_a[63:32]`, and the result bits 63:32 equal `src_b[47:16]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture strobe for the shuffled vector |
| width_code | input | 2 | Sub-word size code |
| sel_field | input | 4 | Source select per pattern entry, entry 0 at bit 3 |
| idx_field | input | 8 | Position index per pattern entry, entry 0 at bits 7:6 |
| src_a | input | LANES*32 | First source vector (select 0) |
| src_b | input | LANES*32 | Second source vector (select 1) |
| result | output | LANES*32 | Registered shuffled vector |
| valid | output | 1 | One-cycle pulse marking a new result |

## Verification
Assertions check four things on every clock cycle. The valid pulse follows the strobe by exactly one cycle. The result holds while no strobe arrives. An oversize width code captures zeros. The lowest byte of a byte-mode shuffle matches the source byte that entry 0 names.

The bench sweeps every width code, select field and index field on a two-lane and a four-lane instance, using random source data. These sweeps are the only way to show the group offset for later slots, the bit order of the fields in every slot, and the fixed 16-bit example.

// File: rtl/vshuf_pkg.sv
package vshuf_pkg;
   typedef enum logic [1:0] {
      SW_BYTE  = 2'b00,
      SW_HALF  = 2'b01,
      SW_WORD  = 2'b10,
      SW_DWORD = 2'b11
   } sub_width_e;

   localparam int PATTERN_LEN = 4;

   function automatic int code_bits(input int code);
      return 8 << code;
   endfunction
endpackage

// File: rtl/vshuf_field_unpack.sv
module vshuf_field_unpack
   import vshuf_pkg::*;
(
   input  logic [3:0]       sel_field,
   input  logic [7:0]       idx_field,
   output logic [3:0][1:0]  pick_idx,
   output logic [3:0]       pick_src
);
   // Entry 0 sits in the most significant position of both fields.
   for (genvar g = 0; g < PATTERN_LEN; g++) begin : g_entry
      assign pick_idx[g] = idx_field[7-2*g -: 2];
      assign pick_src[g] = sel_field[3-g];
   end
endmodule

// File: rtl/vshuf_net.sv
module vshuf_net #(
   parameter int VEC_W = 64,
   parameter int SUB_W = 8
) (
   input  logic [VEC_W-1:0]  src_a,
   input  logic [VEC_W-1:0]  src_b,
   input  logic [3:0][1:0]   pick_idx,
   input  logic [3:0]        pick_src,
   output logic [VEC_W-1:0]  shuffled
);
   localparam int SLOTS = VEC_W / SUB_W;
   localparam int IW    = $clog2(SLOTS);

   if (VEC_W % SUB_W != 0 || SLOTS < 4) begin : g_bad_geom
      $error("vshuf_net: VEC_W must hold at least four whole sub-words");
   end

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      localparam int GRP = i % 4;
      localparam int OFS = i / 4;
      logic [IW-1:0]    pos;
      logic [VEC_W-1:0] src;
      // n + i/4 never exceeds SLOTS-1 because SLOTS >= 4
      assign pos = IW'(pick_idx[GRP]) + IW'(OFS);
      assign src = pick_src[GRP] ? src_b : src_a;
      assign shuffled[i*SUB_W +: SUB_W] = src[pos*SUB_W +: SUB_W];
   end
endmodule

// File: rtl/vshuf_unit.sv
module vshuf_unit
   import vshuf_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [1:0]            width_code,
   input  logic [3:0]            sel_field,
   input  logic [7:0]            idx_field,
   input  logic [LANES*32-1:0]   src_a,
   input  logic [LANES*32-1:0]   src_b,
   output logic [LANES*32-1:0]   result,
   output logic                  valid
);
   localparam int VEC_W   = LANES * 32;
   localparam int MAX_SUB = VEC_W / PATTERN_LEN;

   if (LANES < 2 || LANES % 2 != 0) begin : g_bad_lanes
      $error("vshuf_unit: LANES must be even and at least 2");
   end

   logic [3:0][1:0]  pick_idx;
   logic [3:0]       pick_src;
   logic [VEC_W-1:0] cand [4];
   logic [VEC_W-1:0] shuffled;

   vshuf_field_unpack u_unpack (
      .sel_field (sel_field),
      .idx_field (idx_field),
      .pick_idx  (pick_idx),
      .pick_src  (pick_src)
   );

   // One network per legal sub-word width; oversize widths yield zero.
   for (genvar c = 0; c < 4; c++) begin : g_width
      localparam int SW = code_bits(c);
      if (SW <= MAX_SUB) begin : g_net
         vshuf_net #(.VEC_W(VEC_W), .SUB_W(SW)) u_net (
            .src_a    (src_a),
            .src_b    (src_b),
            .pick_idx (pick_idx),
            .pick_src (pick_src),
            .shuffled (cand[c])
         );
      end else begin : g_none
         assign cand[c] = '0;
      end
   end

   always_comb shuffled = cand[width_code];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result <= '0;
         valid  <= 1'b0;
      end else begin
         valid <= start;
         if (start) result <= shuffled;
      end
   end

   assert_valid_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> valid);
   assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !valid);
   assert_hold_without_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(result));
   assert_oversize_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && ((32'd8 << width_code) > MAX_SUB)) |=> (result == '0));
   // R5 R6: byte mode, slot 0 comes from the byte named by entry 0
   assert_byte_slot0_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && width_code == SW_BYTE) |=>
      (result[7:0] == 8'($past(sel_field[3] ? src_b : src_a) >> {$past(idx_field[7:6]), 3'b000})));
endmodule

// File: tb/vshuf_unit_test.sv
module vshuf_unit_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [1:0]   width_code = 2'b00;
   logic [3:0]   sel_field = 4'h0;
   logic [7:0]   idx_field = 8'h00;
   logic [127:0] a = '0;
   logic [127:0] b = '0;
   logic [63:0]  res2;
   logic [127:0] res4;
   logic         v2, v4;
   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   vshuf_unit #(.LANES(2)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .width_code(width_code),
      .sel_field(sel_field), .idx_field(idx_field),
      .src_a(a[63:0]), .src_b(b[63:0]), .result(res2), .valid(v2));

   vshuf_unit #(.LANES(4)) uut_wide (
      .clk(clk), .rst_n(rst_n), .start(start), .width_code(width_code),
      .sel_field(sel_field), .idx_field(idx_field),
      .src_a(a), .src_b(b), .result(res4), .valid(v4));

   function automatic logic [127:0] model(input int vw, input int code,
         input logic [3:0] sel, input logic [7:0] idx,
         input logic [127:0] sa, input logic [127:0] sb);
      logic [127:0] r = '0;
      int w = 8 << code;
      if (w > vw / 4) return r;
      for (int i = 0; i < vw / w; i++) begin
         int g = i % 4;
         int p = int'(idx[7-2*g -: 2]) + i / 4;
         for (int j = 0; j < w; j++)
            r[i*w+j] = sel[3-g] ? sb[p*w+j] : sa[p*w+j];
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic randomize_src();
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
   endtask

   initial begin
      #(8 * 120000);
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [127:0] e2, e4, hold2, hold4;
      repeat (3) @(negedge clk);
      check(res2 == '0 && !v2, "R1 reset narrow", {64'h0, res2}, '0);
      check(res4 == '0 && !v4, "R1 reset wide", res4, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(res2 == '0 && !v2 && res4 == '0 && !v4, "R1 after release",
            {63'h0, v2, res2}, '0);

      // R9 fixed example on the two-lane instance
      randomize_src();
      width_code = 2'b01; idx_field = 8'b10110110; sel_field = 4'b0011;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(res2[31:0] == a[63:32], "R9 low word", {96'h0, res2[31:0]}, {96'h0, a[63:32]});
      check(res2[63:32] == b[47:16], "R9 high word", {96'h0, res2[63:32]}, {96'h0, b[47:16]});
      @(negedge clk);

      for (int code = 0; code < 4; code++) begin
         for (int s = 0; s < 16; s++) begin
            for (int n = 0; n < 256; n++) begin
               string t2, t4;
               randomize_src();
               width_code = 2'(code); sel_field = 4'(s); idx_field = 8'(n);
               e2 = model(64, code, 4'(s), 8'(n), a, b);
               e4 = model(128, code, 4'(s), 8'(n), a, b);
               t2 = ((8 << code) > 16) ? "R8 narrow" : "R4 R5 R6 R7 narrow";
               t4 = ((8 << code) > 32) ? "R8 wide" : "R4 R5 R6 R7 wide";
               start = 1'b1;
               @(negedge clk);
               start = 1'b0;
               check(v2 && v4, "R2 valid after start", {126'h0, v2, v4}, 128'h3);
               check(res2 == e2[63:0], t2, {64'h0, res2}, {64'h0, e2[63:0]});
               check(res4 == e4, t4, res4, e4);
               hold2 = {64'h0, res2};
               hold4 = res4;
               randomize_src();
               idx_field = ~idx_field; sel_field = ~sel_field;
               @(negedge clk);
               check(!v2 && !v4, "R2 valid single cycle", {126'h0, v2, v4}, '0);
               check({64'h0, res2} == hold2 && res4 == hold4, "R3 hold",
                     res4 ^ hold4, '0);
            end
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule